// File: doc/BRIEF.md
# Reloadable Bit-Rate Tick Generator

This block turns the system clock into a bit-rate enable: a one-cycle `tick` pulse that serial logic elsewhere uses to advance by one bit time. The clock first passes a free-running power-of-two prescaler, which divides by 8 by default. The prescaler's terminal count then steps an 8-bit down-counter. Each time the counter is stepped while it sits at zero, it takes a fresh value from a reload register and the block emits a tick. The bit period is therefore (divisor + 1) × 8 clock cycles.

The host sets the rate by writing a divisor. That write lands only in the reload register, so the interval already in progress finishes at its old length, and the new divisor governs every interval after the next reload. The read port always shows the live counter value, not the stored divisor. After reset everything is zero, which gives the fastest rate, one tick every 8 clocks.

Top module: `rate_tick_gen`

## Requirements
- R1: While `rst` is high and in the first cycle after it falls, `tick` is 0 and `rd_data` is 00h. The first `tick` appears 8 cycles after `rst` falls.
- R2: With divisor D in force, consecutive `tick` pulses are exactly (D + 1) × 8 clock cycles apart, for every D from 00h to FFh.
- R3: `tick` is high for exactly one cycle per interval.
- R4: A write (`wr_en` high with `wr_data`) stores `wr_data` in the reload register. It does not alter the value shown on `rd_data`.
- R5: A divisor written during an interval first takes effect at the next reload. The interval that is running completes at the length set by the previous divisor.
- R6: `rd_data` shows the live counter. Within an interval started with loaded value L, `rd_data` equals L − ⌊n/8⌋ at n cycles after the tick, for n below (L + 1) × 8.
- R7: With divisor 00h, `tick` fires every 8 cycles, on each prescaler terminal count.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| wr_en | input | 1 | Divisor write strobe |
| wr_data | input | 8 | Divisor value to store in the reload register |
| rd_data | output | 8 | Live value of the down-counter |
| tick | output | 1 | One-cycle bit-rate enable |

## Verification
The bound checker confirms on every cycle the local stepping rules. The counter holds between prescaler terminal counts and drops by one on a terminal count when it is nonzero. On a terminal count at zero it reloads from the stored divisor and raises `tick` in the next cycle, and at no other time. A write updates the stored divisor on the next edge, and `tick` never lasts two cycles. What only the bench's scenarios can show is how those rules add up over time. That covers the full (D + 1) × 8 period for a sweep of divisors, the deferred take-up of a new divisor across an interval boundary, and the exact cycle of the first tick after reset.

// File: rtl/rtg_pkg.sv
package rtg_pkg;
   localparam int RTG_CNT_W_DEF = 8;
   localparam int RTG_PRE_W_DEF = 3;

   function automatic int rtg_period(input int divisor, input int pre_w);
      return (divisor + 1) * (1 << pre_w);
   endfunction
endpackage

// File: rtl/rtg_prescale.sv
module rtg_prescale #(
   parameter int PRE_W = 3
) (
   input  logic clk,
   input  logic rst,
   output logic tc
);
   generate
      if (PRE_W == 0) begin : g_bypass
         assign tc = 1'b1;
      end else begin : g_count
         logic [PRE_W-1:0] pre_q;
         always_ff @(posedge clk) begin
            if (rst) pre_q <= '0;
            else     pre_q <= pre_q + 1'b1;
         end
         assign tc = &pre_q;
      end
   endgenerate
endmodule

// File: rtl/rtg_reload_reg.sv
module rtg_reload_reg #(
   parameter int               CNT_W   = 8,
   parameter logic [CNT_W-1:0] RST_VAL = '0
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             wr_en,
   input  logic [CNT_W-1:0] wr_data,
   output logic [CNT_W-1:0] value_q
);
   always_ff @(posedge clk) begin
      if (rst)        value_q <= RST_VAL;
      else if (wr_en) value_q <= wr_data;
   end
endmodule

// File: rtl/rtg_down_counter.sv
module rtg_down_counter #(
   parameter int CNT_W = 8
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             step,
   input  logic [CNT_W-1:0] load_val,
   output logic [CNT_W-1:0] cnt_q,
   output logic             wrap
);
   localparam logic [CNT_W-1:0] ZERO = '0;

   assign wrap = step && (cnt_q == ZERO);

   always_ff @(posedge clk) begin
      if (rst)       cnt_q <= ZERO;
      else if (wrap) cnt_q <= load_val;
      else if (step) cnt_q <= cnt_q - 1'b1;
   end
endmodule

// File: rtl/rate_tick_gen.sv
module rate_tick_gen #(
   parameter int CNT_W = rtg_pkg::RTG_CNT_W_DEF,
   parameter int PRE_W = rtg_pkg::RTG_PRE_W_DEF
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             wr_en,
   input  logic [CNT_W-1:0] wr_data,
   output logic [CNT_W-1:0] rd_data,
   output logic             tick
);
   generate
      if (CNT_W < 2 || CNT_W > 32) begin : g_bad_cnt_w
         $error("rate_tick_gen: CNT_W must lie in 2..32");
      end
      if (PRE_W < 0 || PRE_W > 16) begin : g_bad_pre_w
         $error("rate_tick_gen: PRE_W must lie in 0..16");
      end
   endgenerate

   logic             pre_tc;
   logic             wrap;
   logic [CNT_W-1:0] reload_q;
   logic [CNT_W-1:0] cnt_q;

   rtg_prescale #(.PRE_W(PRE_W)) u_pre (
      .clk (clk),
      .rst (rst),
      .tc  (pre_tc)
   );

   rtg_reload_reg #(.CNT_W(CNT_W), .RST_VAL('0)) u_reload (
      .clk     (clk),
      .rst     (rst),
      .wr_en   (wr_en),
      .wr_data (wr_data),
      .value_q (reload_q)
   );

   rtg_down_counter #(.CNT_W(CNT_W)) u_cnt (
      .clk      (clk),
      .rst      (rst),
      .step     (pre_tc),
      .load_val (reload_q),
      .cnt_q    (cnt_q),
      .wrap     (wrap)
   );

   always_ff @(posedge clk) begin
      if (rst) tick <= 1'b0;
      else     tick <= wrap;
   end

   assign rd_data = cnt_q;
endmodule

// File: rtl/rate_tick_gen_chk.sv
module rate_tick_gen_chk #(
   parameter int CNT_W = 8
) (
   input logic             clk,
   input logic             rst,
   input logic             wr_en,
   input logic [CNT_W-1:0] wr_data,
   input logic [CNT_W-1:0] rd_data,
   input logic             tick,
   input logic             pre_tc,
   input logic [CNT_W-1:0] reload_q
);
   localparam logic [CNT_W-1:0] ZERO = '0;

   // R6: counter is steady between prescaler terminal counts
   p_hold_between_steps_r6: assert property (@(posedge clk) disable iff (rst)
      !pre_tc |=> $stable(rd_data));

   // R6: nonzero counter drops by one on a terminal count
   p_step_down_r6: assert property (@(posedge clk) disable iff (rst)
      (pre_tc && rd_data != ZERO) |=> (rd_data == $past(rd_data) - 1'b1));

   // R2: zero counter reloads the stored divisor and ticks
   p_reload_tick_r2: assert property (@(posedge clk) disable iff (rst)
      (pre_tc && rd_data == ZERO) |=> (tick && rd_data == $past(reload_q)));

   // R2: no tick without a reload
   p_no_stray_tick_r2: assert property (@(posedge clk) disable iff (rst)
      !(pre_tc && rd_data == ZERO) |=> !tick);

   // R3: tick never lasts two cycles
   p_tick_single_r3: assert property (@(posedge clk) disable iff (rst)
      tick |=> !tick);

   // R4: a write lands in the reload register
   p_write_stored_r4: assert property (@(posedge clk) disable iff (rst)
      wr_en |=> (reload_q == $past(wr_data)));
endmodule

bind rate_tick_gen rate_tick_gen_chk #(.CNT_W(CNT_W)) u_chk (
   .clk      (clk),
   .rst      (rst),
   .wr_en    (wr_en),
   .wr_data  (wr_data),
   .rd_data  (rd_data),
   .tick     (tick),
   .pre_tc   (pre_tc),
   .reload_q (reload_q)
);

// File: tb/rate_tick_gen_tb.sv
module rate_tick_gen_tb;
   logic       clk = 1'b0;
   logic       rst = 1'b1;
   logic       wr_en = 1'b0;
   logic [7:0] wr_data = 8'h00;
   logic [7:0] rd_data;
   logic       tick;

   int total = 0;
   int bad   = 0;
   bit done  = 0;

   always #4 clk = ~clk;   // 125 MHz

   rate_tick_gen u_dut (
      .clk     (clk),
      .rst     (rst),
      .wr_en   (wr_en),
      .wr_data (wr_data),
      .rd_data (rd_data),
      .tick    (tick)
   );

   task automatic check(input string req, input int act, input int exp);
      total++;
      if (act != exp) begin
         bad++;
         $display("FAIL %s: actual=%0d expected=%0d at %0t", req, act, exp, $time);
      end
   endtask

   // Runs from a negedge with tick just seen (or just after reset) to the next tick.
   // Checks the live count each cycle (R6) and, optionally, that a write leaves it alone (R4).
   task automatic run_interval(input int loaded, input bit do_wr, input int wval, output int n);
      n = 0;
      if (do_wr) begin
         wr_en   = 1'b1;
         wr_data = wval[7:0];
      end
      do begin
         @(negedge clk);
         n++;
         if (n == 1) begin
            wr_en = 1'b0;
            if (do_wr) check("R4 count unchanged by write", int'(rd_data), loaded);
            if (!tick) check("R3 tick low after pulse", int'(tick), 0);
         end
         if (!tick && (n % 8 == 0) && n < (loaded + 1) * 8)
            check("R6 live count", int'(rd_data), loaded - n / 8);
         if (n > 4000) break;
      end while (!tick);
   endtask

   initial begin : watchdog
      repeat (150000) @(posedge clk);
      if (!done) begin
         bad++;
         total++;
         $display("FAIL watchdog: actual=timeout expected=finish");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin : stim
      int n;
      int cur;
      int list [$];
      repeat (3) @(negedge clk);
      check("R1 tick in reset", int'(tick), 0);
      check("R1 count in reset", int'(rd_data), 0);
      rst = 1'b0;
      @(negedge clk);
      check("R1 tick after reset", int'(tick), 0);
      check("R1 count after reset", int'(rd_data), 0);
      // the first negedge has already passed; interval counts from reset release
      run_interval(0, 1'b0, 0, n);
      check("R1 first tick delay", n + 1, 8);

      // R7: divisor zero, several intervals of 8
      for (int k = 0; k < 4; k++) begin
         run_interval(0, 1'b0, 0, n);
         check("R7 divisor 0 period", n, 8);
      end

      for (int d = 1; d <= 40; d++) list.push_back(d);
      list.push_back(255);
      list.push_back(128);
      list.push_back(200);
      list.push_back(0);
      list.push_back(3);
      cur = 0;
      foreach (list[i]) begin
         // R5: write just after a tick; running interval keeps old length
         run_interval(cur, 1'b1, list[i], n);
         check("R5 old divisor finishes", n, rtg_pkg::rtg_period(cur, 3));
         // R2: next interval uses the new divisor
         run_interval(list[i], 1'b0, 0, n);
         check("R2 period", n, rtg_pkg::rtg_period(list[i], 3));
         cur = list[i];
      end

      done = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule